// File: doc/BRIEF.md
# Subfield Bit-Plane Address Data Formatter

This block sits between the pixel pipeline and the column drivers of a plasma panel. It keeps a frame of 8-bit subpixel codes in on-chip storage. When the timing generator scans a line, the block sends that line's column data for one subfield as a serial stream. Each subfield lights a cell only when one particular bit of the cell's code is set. Subfield index 0 is the heaviest (weight 128) and index 7 is the lightest (weight 1). A frame therefore shows each line eight times, once per bit plane.

Storage is double-buffered. New codes are written into a back bank while the front bank is being read. A frame-swap pulse from the timing generator exchanges the two banks, and the exchange waits until the block is idle between lines. The serial chain is as long as the fitted driver chips (outputs per chip × chips per module × modules), and every chain position beyond the last real cell is sent as 0.

For each line the block drives one data bit per cycle with a shift qualifier. It holds blank active during the transfer, then gives a one-cycle latch strobe and a one-cycle done pulse.

Top module: `subfield_plane_fmt`

## Requirements
- R1: While reset is asserted, colData, colShift, colLatch, colBlank, lineDone and busy are all 0.
- R2: A lineReq sampled while busy is 0 is accepted. colShift is 1 in the cycle after the accepting edge and stays 1 for exactly CHAIN consecutive cycles, where CHAIN = DRV_OUTS*DRV_PER_MOD*MODS.
- R3: During a line for subfield index s (0..7), each bit sent for a real cell equals bit (7-s) of that cell's stored 8-bit code. Index 0 therefore carries bit 7 (weight 128) and index 7 carries bit 0.
- R4: Bits are sent in ascending chain position: cell 0 of the requested line first, up to cell CELLS-1. Positions CELLS..CHAIN-1 are sent as 0.
- R5: In the cycle after the last shift cycle, colLatch is 1 for one cycle with colShift 0. In the cycle after that, lineDone is 1 for one cycle. lineDone therefore rises CHAIN+1 cycles after the first shift cycle.
- R6: colBlank is 1 in every shift cycle and in the latch cycle, and 0 in every other cycle.
- R7: A lineReq sampled while busy is 1 is ignored: it adds no shift cycles and does not change the line being sent.
- R8: A write (wrValid with wrLine, wrCell, wrCode) goes to the back bank. Lines sent before the next swap do not show it.
- R9: A frameSwap pulse while busy is deferred. The line in progress finishes from the old front bank, and the swap takes effect before the next accepted line.
- R10: A frameSwap and a lineReq sampled together while idle both take effect, and that line is read from the newly swapped front bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write a code into the back bank |
| wrLine | input | LW | Line index of the write |
| wrCell | input | CW | Cell index of the write |
| wrCode | input | 8 | Subpixel code |
| frameSwap | input | 1 | Request to exchange front and back banks |
| lineReq | input | 1 | Start sending one line |
| reqSubfield | input | 3 | Subfield index, 0 = weight 128 |
| reqLine | input | LW | Line index to send |
| colData | output | 1 | Serial column bit |
| colShift | output | 1 | Shift qualifier for colData |
| colLatch | output | 1 | One-cycle latch strobe to the chain |
| colBlank | output | 1 | Holds driver outputs low during transfer |
| lineDone | output | 1 | One-cycle pulse when the line is latched |
| busy | output | 1 | A line transfer is in progress |

## Verification
The assertions take it for granted that line and cell indices stay inside LINES and CELLS. They also assume a write never lands in the same cycle as an applied swap, and that at most one swap is pending at a time. The stimulus writes only to in-range positions and always separates writes from swap pulses by idle cycles. It sends one mid-line swap at most per line, so the deferred-swap and bank-ownership properties stay well defined. Extra line requests are issued only mid-transfer, to exercise the ignore path.

// File: rtl/sf_fmt_pkg.sv
package sf_fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LATCH,
    ST_DONE
  } fmtState_t;

  // strobes and indices handed from control to datapath each cycle
  typedef struct packed {
    logic        shift;
    logic        latch;
    logic        done;
    logic        swap;
    logic [15:0] pos;
    logic [15:0] line;
    logic [2:0]  subfield;
  } fmtCtl_t;

endpackage

// File: rtl/sf_fmt_ctrl.sv
module sf_fmt_ctrl
  import sf_fmt_pkg::*;
#(
  parameter int CHAIN = 16,
  parameter int LW    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineReq,
  input  logic [2:0]    reqSubfield,
  input  logic [LW-1:0] reqLine,
  input  logic          frameSwap,
  output fmtCtl_t       ctl,
  output logic          busy
);

  localparam logic [15:0] LAST_POS = 16'(CHAIN - 1);

  fmtState_t   state;
  logic [15:0] pos;
  logic [15:0] lineReg;
  logic [2:0]  sfReg;
  logic        swapPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pos     <= '0;
      lineReg <= '0;
      sfReg   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (lineReq) begin
          state   <= ST_SHIFT;
          pos     <= '0;
          sfReg   <= reqSubfield;
          lineReg <= 16'(reqLine);
        end
        ST_SHIFT: begin
          pos <= pos + 16'd1;
          if (pos == LAST_POS) state <= ST_LATCH;
        end
        ST_LATCH: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // a swap waits for the idle state between lines
  always_ff @(posedge clk) begin
    if (!rstN)          swapPend <= 1'b0;
    else if (ctl.swap)  swapPend <= 1'b0;
    else if (frameSwap) swapPend <= 1'b1;
  end

  always_comb begin
    ctl.shift    = (state == ST_SHIFT);
    ctl.latch    = (state == ST_LATCH);
    ctl.done     = (state == ST_DONE);
    ctl.swap     = (state == ST_IDLE) && (swapPend || frameSwap);
    ctl.pos      = pos;
    ctl.line     = lineReg;
    ctl.subfield = sfReg;
  end

  assign busy = (state != ST_IDLE);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(sfReg) && $stable(lineReg)));

  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (pos <= LAST_POS));

  p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (swapPend && state != ST_IDLE) |=> swapPend);

endmodule

// File: rtl/sf_fmt_data.sv
module sf_fmt_data
  import sf_fmt_pkg::*;
#(
  parameter int CELLS = 12,
  parameter int LINES = 4,
  parameter int CHAIN = 16,
  parameter int LW    = 2,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  fmtCtl_t       ctl,
  input  logic          wrValid,
  input  logic [LW-1:0] wrLine,
  input  logic [CW-1:0] wrCell,
  input  logic [7:0]    wrCode,
  output logic          colData,
  output logic          colShift,
  output logic          colLatch,
  output logic          colBlank,
  output logic          lineDone
);

  localparam int DEPTH = LINES * CELLS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    store [2][DEPTH];
  logic          frontBank;
  logic          inRange;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] wrAddr;
  logic [7:0]    rdCode;
  logic [2:0]    bitSel;
  logic          nextBit;

  generate
    if (CHAIN > CELLS) begin : g_pad
      assign inRange = (ctl.pos < 16'(CELLS));
    end else begin : g_nopad
      assign inRange = 1'b1;
    end
  endgenerate

  always_comb begin
    rdAddr  = inRange ? AW'(int'(ctl.line) * CELLS + int'(ctl.pos)) : '0;
    wrAddr  = AW'(int'(wrLine) * CELLS + int'(wrCell));
    rdCode  = store[frontBank][rdAddr];
    bitSel  = 3'd7 - ctl.subfield;
    nextBit = inRange & rdCode[bitSel];
  end

  always_ff @(posedge clk) begin
    if (wrValid) store[~frontBank][wrAddr] <= wrCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontBank <= 1'b0;
      colData   <= 1'b0;
      colShift  <= 1'b0;
      colLatch  <= 1'b0;
      colBlank  <= 1'b0;
      lineDone  <= 1'b0;
    end else begin
      if (ctl.swap) frontBank <= ~frontBank;
      colData  <= ctl.shift ? nextBit : 1'b0;
      colShift <= ctl.shift;
      colLatch <= ctl.latch;
      colBlank <= ctl.shift | ctl.latch;
      lineDone <= ctl.done;
    end
  end

  p_latch_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(colShift) |-> colLatch);

  p_done_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    colLatch |=> (lineDone && !colLatch));

  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(colShift && colLatch));

  p_blank_cover_r6: assert property (@(posedge clk) disable iff (!rstN)
    (colShift || colLatch) |-> colBlank);

  p_swap_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frontBank) |-> (!colBlank && !colShift));

endmodule

// File: rtl/subfield_plane_fmt.sv
module subfield_plane_fmt
  import sf_fmt_pkg::*;
#(
  parameter int CELLS       = 12,
  parameter int LINES       = 4,
  parameter int DRV_OUTS    = 8,
  parameter int DRV_PER_MOD = 1,
  parameter int MODS        = 2,
  localparam int CHAIN      = DRV_OUTS * DRV_PER_MOD * MODS,
  localparam int LW         = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW         = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [LW-1:0] wrLine,
  input  logic [CW-1:0] wrCell,
  input  logic [7:0]    wrCode,
  input  logic          frameSwap,
  input  logic          lineReq,
  input  logic [2:0]    reqSubfield,
  input  logic [LW-1:0] reqLine,
  output logic          colData,
  output logic          colShift,
  output logic          colLatch,
  output logic          colBlank,
  output logic          lineDone,
  output logic          busy
);

  fmtCtl_t ctl;

  sf_fmt_ctrl #(.CHAIN(CHAIN), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineReq(lineReq), .reqSubfield(reqSubfield),
    .reqLine(reqLine), .frameSwap(frameSwap), .ctl(ctl), .busy(busy)
  );

  sf_fmt_data #(.CELLS(CELLS), .LINES(LINES), .CHAIN(CHAIN), .LW(LW), .CW(CW)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrValid(wrValid), .wrLine(wrLine),
    .wrCell(wrCell), .wrCode(wrCode), .colData(colData), .colShift(colShift),
    .colLatch(colLatch), .colBlank(colBlank), .lineDone(lineDone)
  );

endmodule

// File: tb/sim_subfield_plane_fmt.sv
module sim_subfield_plane_fmt;

  localparam int CELLS = 12;
  localparam int LINES = 4;
  localparam int CHAIN = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, wrValid, frameSwap, lineReq;
  logic [1:0] wrLine, reqLine;
  logic [3:0] wrCell;
  logic [7:0] wrCode;
  logic [2:0] reqSubfield;
  logic       colData, colShift, colLatch, colBlank, lineDone, busy;

  subfield_plane_fmt u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrLine(wrLine), .wrCell(wrCell),
    .wrCode(wrCode), .frameSwap(frameSwap), .lineReq(lineReq),
    .reqSubfield(reqSubfield), .reqLine(reqLine), .colData(colData),
    .colShift(colShift), .colLatch(colLatch), .colBlank(colBlank),
    .lineDone(lineDone), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit qExp[$];
  logic [7:0] model [2][LINES*CELLS];
  int front = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor
  bit prevShift = 0, prevLatch = 0;
  int runCount = 0;
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      if (colShift) begin
        if (qExp.size() == 0) check(0, "R7", "unexpected shift", 1, 0);
        else begin
          bit e;
          e = qExp.pop_front();
          check(colData == e, "R3 R4", "column bit", int'(colData), int'(e));
        end
        check(colBlank, "R6", "blank in shift", int'(colBlank), 1);
        runCount++;
      end
      if (prevShift && !colShift) check(colLatch, "R5", "latch after shift", int'(colLatch), 1);
      if (colLatch) begin
        check(runCount == CHAIN, "R2", "shift count", runCount, CHAIN);
        check(colBlank, "R6", "blank in latch", int'(colBlank), 1);
        runCount = 0;
      end
      if (prevLatch) check(lineDone && !colLatch, "R5", "done after latch", int'(lineDone), 1);
      if (!colShift && !colLatch) check(!colBlank, "R6", "blank idle", int'(colBlank), 0);
      prevShift = colShift;
      prevLatch = colLatch;
    end
  end

  task automatic writeCell(input int ln, input int cl, input logic [7:0] code);
    @(negedge clk);
    wrValid = 1; wrLine = 2'(ln); wrCell = 4'(cl); wrCode = code;
    model[1-front][ln*CELLS+cl] = code;
    @(negedge clk);
    wrValid = 0;
  endtask

  task automatic swapIdle();
    @(negedge clk);
    frameSwap = 1; front = 1 - front;
    @(negedge clk);
    frameSwap = 0;
    @(negedge clk);
  endtask

  // midEvent: 0 none, 1 extra request while busy, 2 swap while busy
  task automatic runLine(input int sf, input int ln, input bit swapToo, input int midEvent);
    realtime tFirst;
    int guard;
    @(negedge clk);
    if (swapToo) begin frameSwap = 1; front = 1 - front; end
    lineReq = 1; reqSubfield = 3'(sf); reqLine = 2'(ln);
    for (int p = 0; p < CHAIN; p++)
      qExp.push_back(p < CELLS ? model[front][ln*CELLS+p][7-sf] : 1'b0);
    @(negedge clk);
    lineReq = 0; frameSwap = 0;
    @(posedge clk); #5;
    check(colShift, "R2", "first shift one cycle after accept", int'(colShift), 1);
    tFirst = $realtime;
    if (midEvent != 0) begin
      repeat (3) @(negedge clk);
      if (midEvent == 1) begin
        lineReq = 1; reqSubfield = 3'((sf + 3) % 8); reqLine = 2'((ln + 1) % LINES);
      end else begin
        frameSwap = 1; front = 1 - front;
      end
      @(negedge clk);
      lineReq = 0; frameSwap = 0;
    end
    guard = 0;
    while (1) begin
      @(posedge clk); #5;
      guard++;
      if (lineDone || guard > 200) break;
    end
    check(lineDone, "R5", "lineDone seen", int'(lineDone), 1);
    check(int'(($realtime - tFirst) / 20.0) == CHAIN + 1, "R5", "done delay cycles",
          int'(($realtime - tFirst) / 20.0), CHAIN + 1);
    @(negedge clk);
  endtask

  initial begin
    rstN = 0; wrValid = 0; frameSwap = 0; lineReq = 0;
    wrLine = 0; wrCell = 0; wrCode = 0; reqSubfield = 0; reqLine = 0;
    repeat (3) @(negedge clk);
    check(!colData && !colShift && !colLatch, "R1", "data strobes in reset",
          int'({colData, colShift, colLatch}), 0);
    check(!colBlank && !lineDone && !busy, "R1", "status in reset",
          int'({colBlank, lineDone, busy}), 0);
    rstN = 1;
    @(negedge clk);

    // pattern A, with all-ones and all-zero cells on line 0
    for (int ln = 0; ln < LINES; ln++)
      for (int cl = 0; cl < CELLS; cl++) begin
        logic [7:0] c;
        c = 8'((ln*53 + cl*29 + 7) & 255);
        if (ln == 0 && cl == 0) c = 8'hFF;
        if (ln == 0 && cl == 1) c = 8'h00;
        writeCell(ln, cl, c);
      end
    swapIdle();

    // R3 R4: every subfield on two lines, ends of range on others
    for (int sf = 0; sf < 8; sf++) runLine(sf, 0, 0, 0);
    for (int sf = 0; sf < 8; sf++) runLine(sf, 1, 0, 0);
    runLine(0, 2, 0, 0);
    runLine(7, 3, 0, 0);

    // R8: pattern B into back bank, front must still show A
    for (int ln = 0; ln < LINES; ln++)
      for (int cl = 0; cl < CELLS; cl++)
        writeCell(ln, cl, ~8'((ln*53 + cl*29 + 7) & 255));
    runLine(0, 0, 0, 0);
    runLine(4, 2, 0, 0);

    // R9: swap during a line is deferred; next line shows B
    runLine(3, 1, 0, 2);
    runLine(3, 1, 0, 0);
    runLine(6, 3, 0, 0);

    // R7: request while busy ignored
    runLine(5, 2, 0, 1);
    repeat (4) @(negedge clk);
    check(qExp.size() == 0, "R7", "leftover expected bits", qExp.size(), 0);
    check(!busy, "R7", "idle after ignored request", int'(busy), 0);

    // R10: swap and request in the same idle cycle
    for (int ln = 0; ln < LINES; ln++)
      for (int cl = 0; cl < CELLS; cl++)
        writeCell(ln, cl, 8'(ln*CELLS + cl + 100));
    runLine(1, 2, 1, 0);
    runLine(7, 0, 0, 0);

    repeat (5) @(negedge clk);
    check(qExp.size() == 0, "R2", "all expected bits consumed", qExp.size(), 0);
    finishRun();
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      finishRun();
    end
  end

endmodule